// File: doc/BRIEF.md
# Data Address Generator

This block forms the effective address for every data-space access of a small 8-bit controller core. It owns the three 16-bit pointer pairs: X in R27:R26, Y in R29:R28 and Z in R31:R30. It also owns the stack pointer. The core gives it an access mode and a pointer select for each instruction. The block then returns the effective address, the region that address falls in, and an access strobe. On the following clock edge it writes back the pointer or stack pointer that the mode modifies.

The data space is linear. Addresses 0x0000 to 0x001F hit the general registers, 0x0020 to 0x005F hit the I/O registers, and 0x0060 up to RAMEND hit SRAM. Program-memory byte reads use Z as a byte address. The word address and the byte lane are both derived from Z. The core loads a pointer or the stack pointer through a separate load port, and it reads all four values back on dedicated outputs.

The address outputs are combinational from the current request and the pointer state. Pointer updates take effect at the rising clock edge after the request.

Top module: `data_addr_gen`

## Requirements
- R1: After reset, X, Y and Z read 0 and SP reads RAMEND (default 0x045F). With no request pending, the strobe and both error flags are low.
- R2: Mode 0 (direct) puts `acc_direct` on `ea` and leaves every pointer and SP unchanged.
- R3: Data-space addresses are classified by `ea_region`: 0 for general registers (below 0x20), 1 for I/O (0x20 to 0x5F), and 2 for SRAM (0x60 to RAMEND). Program-memory reads report region 3. A legal, in-range access raises `ea_strobe`.
- R4: A data-space effective address above RAMEND raises `range_err` and keeps `ea_strobe` low. Any pointer or SP update of the mode still happens.
- R5: Mode 1 (indirect) outputs the selected pointer unchanged. `acc_ptr` encodes 0 = X, 1 = Y, 2 = Z.
- R6: Mode 2 (displacement) with Y or Z outputs the pointer plus the zero-extended 6-bit `acc_disp` (0 to 63). The pointer is not changed.
- R7: Mode 2 with X, any pointer-based mode (1 to 4) with `acc_ptr` = 3, and mode codes 9 to 15 all raise `mode_err`. Such a request keeps `ea_strobe` and `range_err` low and updates no pointer and no SP.
- R8: Mode 3 (post-increment) outputs the selected pointer, which then becomes pointer + 1.
- R9: Mode 4 (pre-decrement) outputs pointer − 1, and the pointer takes that value.
- R10: Mode 5 (push) outputs SP, and SP then becomes SP − 1.
- R11: Mode 6 (pop) outputs SP + 1, and SP takes that value.
- R12: Mode 7 (program-memory byte read) outputs Z >> 1 as the word address. `pm_hi_byte` equals Z[0], where 1 selects the high byte. Z is unchanged. Mode 8 does the same and then sets Z to Z + 1.
- R13: All pointer and SP arithmetic wraps modulo 2^16.
- R14: `ld_valid` writes `ld_value` into the register chosen by `ld_sel` (0 = X, 1 = Y, 2 = Z, 3 = SP). If the load and an access update the same register in one cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_mode | input | 4 | Addressing mode code |
| acc_ptr | input | 2 | Pointer select for pointer-based modes |
| acc_disp | input | 6 | Unsigned displacement |
| acc_direct | input | 16 | Address for direct mode |
| ld_valid | input | 1 | Pointer/SP load request |
| ld_sel | input | 2 | Load target |
| ld_value | input | 16 | Load value |
| ea | output | 16 | Effective address (word address for program memory) |
| ea_region | output | 2 | Region of the access |
| ea_strobe | output | 1 | Access may proceed |
| pm_hi_byte | output | 1 | High-byte select for program-memory reads |
| range_err | output | 1 | Data address above RAMEND |
| mode_err | output | 1 | Illegal mode or pointer combination |
| ptr_x | output | 16 | Current X |
| ptr_y | output | 16 | Current Y |
| ptr_z | output | 16 | Current Z |
| sp_out | output | 16 | Current stack pointer |

## Verification
Some properties are checked on every cycle:
- A range error never coexists with a strobe.
- Strobed SRAM addresses lie within bounds.
- A rejected request leaves all pointers untouched.
- The pointer write-back of post-increment, pre-decrement, push and pop matches the address that was issued.

Other behaviour is shown only by the bench's scenarios:
- Concrete address values.
- Region boundaries at 0x1F/0x20, 0x5F/0x60 and RAMEND/RAMEND+1.
- Wrap at 0x0000 and 0xFFFF.
- Byte-lane selection from Z[0].
- Load-over-update priority.

// File: rtl/data_addr_gen.sv
module data_addr_gen #(
  parameter int AW = 16,
  parameter int DISP_W = 6,
  parameter logic [AW-1:0] RAMEND = 16'h045F,
  parameter logic [AW-1:0] IO_BASE = 16'h0020,
  parameter logic [AW-1:0] SRAM_BASE = 16'h0060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [3:0]        acc_mode,
  input  logic [1:0]        acc_ptr,
  input  logic [DISP_W-1:0] acc_disp,
  input  logic [AW-1:0]     acc_direct,
  input  logic              ld_valid,
  input  logic [1:0]        ld_sel,
  input  logic [AW-1:0]     ld_value,
  output logic [AW-1:0]     ea,
  output logic [1:0]        ea_region,
  output logic              ea_strobe,
  output logic              pm_hi_byte,
  output logic              range_err,
  output logic              mode_err,
  output logic [AW-1:0]     ptr_x,
  output logic [AW-1:0]     ptr_y,
  output logic [AW-1:0]     ptr_z,
  output logic [AW-1:0]     sp_out
);
  localparam logic [3:0] M_DIR = 4'd0, M_IND = 4'd1, M_DISP = 4'd2, M_PINC = 4'd3,
                         M_PDEC = 4'd4, M_PUSH = 4'd5, M_POP = 4'd6, M_PM = 4'd7,
                         M_PMINC = 4'd8;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] ptr_q [3];
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sel;
  logic          bad, is_data, ptr_wb, sp_wb;
  logic [1:0]    wb_idx;
  logic [AW-1:0] wb_val, sp_val, addr;

  assign sel = (acc_ptr == 2'd0) ? ptr_q[0] :
               (acc_ptr == 2'd1) ? ptr_q[1] : ptr_q[2];

  always_comb begin
    addr    = '0;
    bad     = 1'b0;
    is_data = 1'b1;
    ptr_wb  = 1'b0;
    wb_idx  = acc_ptr;
    wb_val  = sel;
    sp_wb   = 1'b0;
    sp_val  = sp_q;
    pm_hi_byte = 1'b0;
    case (acc_mode)
      M_DIR:  addr = acc_direct;
      M_IND: begin
        addr = sel;
        bad  = (acc_ptr == 2'd3);
      end
      M_DISP: begin
        addr = sel + AW'(acc_disp);
        bad  = (acc_ptr == 2'd0) || (acc_ptr == 2'd3);
      end
      M_PINC: begin
        addr   = sel;
        bad    = (acc_ptr == 2'd3);
        ptr_wb = 1'b1;
        wb_val = sel + ONE;
      end
      M_PDEC: begin
        addr   = sel - ONE;
        bad    = (acc_ptr == 2'd3);
        ptr_wb = 1'b1;
        wb_val = sel - ONE;
      end
      M_PUSH: begin
        addr   = sp_q;
        sp_wb  = 1'b1;
        sp_val = sp_q - ONE;
      end
      M_POP: begin
        addr   = sp_q + ONE;
        sp_wb  = 1'b1;
        sp_val = sp_q + ONE;
      end
      M_PM, M_PMINC: begin
        is_data    = 1'b0;
        addr       = {1'b0, ptr_q[2][AW-1:1]};
        pm_hi_byte = ptr_q[2][0];
        wb_idx     = 2'd2;
        ptr_wb     = (acc_mode == M_PMINC);
        wb_val     = ptr_q[2] + ONE;
      end
      default: bad = 1'b1;
    endcase
  end

  assign ea        = addr;
  assign ea_region = !is_data ? 2'd3 :
                     (addr < IO_BASE) ? 2'd0 :
                     (addr < SRAM_BASE) ? 2'd1 : 2'd2;
  assign mode_err  = acc_valid && bad;
  assign range_err = acc_valid && !bad && is_data && (addr > RAMEND);
  assign ea_strobe = acc_valid && !bad && !(is_data && (addr > RAMEND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
      ptr_q[2] <= '0;
      sp_q     <= RAMEND;
    end else begin
      if (acc_valid && !bad && ptr_wb) ptr_q[wb_idx] <= wb_val;
      if (acc_valid && !bad && sp_wb)  sp_q <= sp_val;
      if (ld_valid) begin
        if (ld_sel == 2'd3) sp_q <= ld_value;
        else                ptr_q[ld_sel] <= ld_value;
      end
    end
  end

  assign ptr_x  = ptr_q[0];
  assign ptr_y  = ptr_q[1];
  assign ptr_z  = ptr_q[2];
  assign sp_out = sp_q;

  assert_oor_blocks_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> !ea_strobe);

  assert_sram_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_strobe && ea_region == 2'd2) |-> (ea >= SRAM_BASE && ea <= RAMEND));

  assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !ld_valid) |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z) && $stable(sp_out)));

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!ea_strobe && !range_err));

  assert_postinc_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == M_PINC && acc_ptr == 2'd1 && !ld_valid) |=> ptr_y == $past(ea) + ONE);

  assert_predec_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == M_PDEC && acc_ptr == 2'd0 && !ld_valid) |=> ptr_x == $past(ea));

  assert_push_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == M_PUSH && !ld_valid) |=> sp_out == $past(ea) - ONE);

  assert_pop_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode == M_POP && !ld_valid) |=> sp_out == $past(ea));
endmodule

// File: tb/data_addr_gen_tb.sv
module data_addr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [3:0] acc_mode = '0;
  logic [1:0] acc_ptr = '0;
  logic [5:0] acc_disp = '0;
  logic [15:0] acc_direct = '0;
  logic ld_valid = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [15:0] ld_value = '0;
  logic [15:0] ea, ptr_x, ptr_y, ptr_z, sp_out;
  logic [1:0] ea_region;
  logic ea_strobe, pm_hi_byte, range_err, mode_err;
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] s_ea;
  logic [1:0] s_reg;
  logic s_stb, s_hi, s_rerr, s_merr;

  always #2.5 clk = ~clk;

  data_addr_gen u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = s; ld_value = v;
    @(posedge clk); #1;
    ld_valid = 1'b0;
  endtask

  task automatic access(input logic [3:0] m, input logic [1:0] p, input logic [5:0] d, input logic [15:0] a);
    @(negedge clk);
    acc_valid = 1'b1; acc_mode = m; acc_ptr = p; acc_disp = d; acc_direct = a;
    #1;
    s_ea = ea; s_reg = ea_region; s_stb = ea_strobe; s_hi = pm_hi_byte;
    s_rerr = range_err; s_merr = mode_err;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 x", ptr_x, 0); chk("R1 y", ptr_y, 0); chk("R1 z", ptr_z, 0);
    chk("R1 sp", sp_out, 16'h045F);
    chk("R1 strobe", ea_strobe, 0); chk("R1 errs", {range_err, mode_err}, 0);
  endtask

  task automatic t_direct;
    access(4'd0, 2'd0, 6'd0, 16'h013C);
    chk("R2 ea", s_ea, 16'h013C); chk("R3 sram", s_reg, 2); chk("R3 stb", s_stb, 1);
    chk("R2 ptrs", {ptr_x, ptr_y, ptr_z, sp_out}, {16'h0, 16'h0, 16'h0, 16'h045F});
    access(4'd0, 2'd0, 6'd0, 16'h001F); chk("R3 gpr", s_reg, 0);
    access(4'd0, 2'd0, 6'd0, 16'h0020); chk("R3 io lo", s_reg, 1);
    access(4'd0, 2'd0, 6'd0, 16'h005F); chk("R3 io hi", s_reg, 1);
    access(4'd0, 2'd0, 6'd0, 16'h0060); chk("R3 sram lo", s_reg, 2);
    access(4'd0, 2'd0, 6'd0, 16'h045F); chk("R4 at end", {s_stb, s_rerr}, 2'b10);
    access(4'd0, 2'd0, 6'd0, 16'h0460); chk("R4 past end", {s_stb, s_rerr}, 2'b01);
  endtask

  task automatic t_indirect;
    load(2'd0, 16'h0100);
    access(4'd1, 2'd0, 6'd0, 16'h0);
    chk("R5 ea", s_ea, 16'h0100); chk("R5 x kept", ptr_x, 16'h0100);
  endtask

  task automatic t_disp;
    load(2'd1, 16'h0200);
    access(4'd2, 2'd1, 6'd63, 16'h0);
    chk("R6 ea", s_ea, 16'h0200 + 63); chk("R6 y kept", ptr_y, 16'h0200);
    load(2'd2, 16'h0440);
    access(4'd2, 2'd2, 6'd63, 16'h0);
    chk("R4 disp ea", s_ea, 16'h047F); chk("R4 disp flags", {s_stb, s_rerr}, 2'b01);
  endtask

  task automatic t_illegal;
    access(4'd2, 2'd0, 6'd5, 16'h0);
    chk("R7 x disp", {s_merr, s_stb, s_rerr}, 3'b100); chk("R7 x kept", ptr_x, 16'h0100);
    access(4'd3, 2'd3, 6'd0, 16'h0);
    chk("R7 sel3", s_merr, 1);
    chk("R7 kept", {ptr_x, ptr_y, ptr_z}, {16'h0100, 16'h0200, 16'h0440});
    access(4'd12, 2'd1, 6'd0, 16'h0);
    chk("R7 code12", {s_merr, s_stb}, 2'b10); chk("R7 sp kept", sp_out, 16'h045F);
  endtask

  task automatic t_postinc;
    load(2'd2, 16'h0060);
    access(4'd3, 2'd2, 6'd0, 16'h0);
    chk("R8 ea", s_ea, 16'h0060); chk("R8 z", ptr_z, 16'h0061);
    load(2'd0, 16'hFFFF);
    access(4'd3, 2'd0, 6'd0, 16'h0);
    chk("R13 inc ea", {s_ea, s_rerr}, {16'hFFFF, 1'b1}); chk("R13 x wrap", ptr_x, 16'h0000);
  endtask

  task automatic t_predec;
    load(2'd1, 16'h0100);
    access(4'd4, 2'd1, 6'd0, 16'h0);
    chk("R9 ea", s_ea, 16'h00FF); chk("R9 y", ptr_y, 16'h00FF);
    access(4'd4, 2'd0, 6'd0, 16'h0);
    chk("R13 dec ea", s_ea, 16'hFFFF); chk("R13 x wrap", ptr_x, 16'hFFFF);
  endtask

  task automatic t_stack;
    access(4'd5, 2'd0, 6'd0, 16'h0);
    chk("R10 ea", s_ea, 16'h045F); chk("R10 sp", sp_out, 16'h045E);
    access(4'd6, 2'd0, 6'd0, 16'h0);
    chk("R11 ea", s_ea, 16'h045F); chk("R11 sp", sp_out, 16'h045F);
    load(2'd3, 16'h0000);
    access(4'd5, 2'd0, 6'd0, 16'h0);
    chk("R13 sp wrap", sp_out, 16'hFFFF);
  endtask

  task automatic t_pm;
    load(2'd2, 16'h07D1);
    access(4'd7, 2'd0, 6'd0, 16'h0);
    chk("R12 word", s_ea, 16'h03E8); chk("R12 hi", {s_hi, s_reg, s_stb}, 4'b1111);
    chk("R12 z kept", ptr_z, 16'h07D1);
    load(2'd2, 16'h07D0);
    access(4'd8, 2'd1, 6'd0, 16'h0);
    chk("R12 lo", {s_ea, s_hi}, {16'h03E8, 1'b0}); chk("R12 z inc", ptr_z, 16'h07D1);
  endtask

  task automatic t_conflict;
    load(2'd1, 16'h0010);
    @(negedge clk);
    acc_valid = 1'b1; acc_mode = 4'd3; acc_ptr = 2'd1;
    ld_valid = 1'b1; ld_sel = 2'd1; ld_value = 16'h0300;
    @(posedge clk); #1;
    acc_valid = 1'b0; ld_valid = 1'b0;
    chk("R14 load wins", ptr_y, 16'h0300);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 t_reset;
    t_direct; t_indirect; t_disp; t_illegal; t_postinc;
    t_predec; t_stack; t_pm; t_conflict;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule